// File: doc/BRIEF.md
# Windowed memory load monitor

This block measures the traffic on a set of memory-controller channels, two by default, over back-to-back windows of fixed length. Each channel raises a one-cycle event for every four-beat burst command it issues. A shared timer divides time into windows of a programmed number of reference-clock cycles. At the last cycle of each window the block stores, for every channel, the number of bursts it saw and the number of cycles in the window. It then clears the live counters and begins the next window on the following cycle, so no event is lost at the boundary.

At each window end, every channel's burst total is compared with a programmable upper and lower limit, both in burst units. A total above the upper limit sets that channel's "over" status bit, and a total below the lower limit sets its "under" bit. Status bits stay set until software clears them. Unmasked status bits are ORed onto a single interrupt line. Software reaches the block over a plain 32-bit register bus. Writes are single-cycle strobes and reads are combinational. A frequency governor typically uses the block by setting a window of 1,200,000 cycles of a 24 MHz reference (50 ms), loading limits derived from its current operating point, and reacting to the interrupt.

Top module: `memload_monitor`

## Requirements
- R1: Writing the control register (offset 0x04) updates low bit b only when write-data bit 16+b is 1. All other low bits keep their value. The implemented bits are: bit 0 timer enable, bit 2 and bit 4 two memory-type mode selects, and bit 3 monitor enable. Bit 1 and all bits above 4 always read 0.
- R2: Register offsets: 0x08 status, 0x0C mask, 0x10 window length, 0x14 lower limit, 0x18 upper limit. Channel i stores its cycle count at 0x28 + 20·i and its burst count at 0x2C + 20·i. Every other offset reads 0.
- R3: With window length N (N ≥ 1; 0 acts as 1), a window spans N running cycles and each channel's stored cycle count equals N.
- R4: Each channel's stored burst count equals the events seen in the window's N cycles, including its first and last cycle. Consecutive windows lose no event.
- R5: At a window end, a burst total strictly greater than the upper limit sets status bit 2·i+1 for channel i.
- R6: At a window end, a burst total strictly less than the lower limit sets status bit 2·i for channel i.
- R7: Status bits are sticky. Writing 1 to a low bit of the status register clears that bit, and writing 0 leaves it unchanged.
- R8: The interrupt is high when any status bit is set whose mask bit (same position in the mask register) is 0. After reset all mask bits are 1.
- R9: Unless control bits 0 and 3 are both 1, the timer and live counters hold at zero, no window ends, and stored counts and status are left unchanged.
- R10: The mode-select bits are stored and read back but do not change counting or comparison.
- R11: After reset, control, status, window length, both limits and all stored counts read 0, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Register byte offset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| chan_burst | input | NCH | Per-channel burst event, one cycle per burst |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
A register write is sampled at the clock edge that ends its strobe cycle and is readable before the next edge. The window started by the enabling write covers the following N edges. Stored counts and status bits change at the N-th edge, and the interrupt follows in the same cycle. The bench drives inputs and reads back values at falling edges. It places each burst pattern in a known cycle of the window and reads the results at the falling edge just after the window's last rising edge, before the disabling write lands. With a one-cycle window the next edge would overwrite the result, so the bench reads it in that same half cycle.

// File: rtl/lm_pkg.sv
package lm_pkg;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 8;

    localparam logic [AW-1:0] OFF_CTRL   = 8'h04;
    localparam logic [AW-1:0] OFF_STAT   = 8'h08;
    localparam logic [AW-1:0] OFF_MASK   = 8'h0C;
    localparam logic [AW-1:0] OFF_WLEN   = 8'h10;
    localparam logic [AW-1:0] OFF_LOW    = 8'h14;
    localparam logic [AW-1:0] OFF_HIGH   = 8'h18;
    localparam logic [AW-1:0] OFF_CH_CYC = 8'h28;
    localparam logic [AW-1:0] OFF_CH_ACC = 8'h2C;
    localparam int unsigned   CH_STRIDE  = 20;

    localparam int unsigned CTRL_W     = 5;
    localparam int unsigned CB_TIMER   = 0;
    localparam int unsigned CB_MONITOR = 3;
    localparam logic [CTRL_W-1:0] CTRL_IMPL = 5'b11101;
endpackage

// File: rtl/lm_window_timer.sv
module lm_window_timer #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] win_len,
    output logic             win_end,
    output logic [CNT_W-1:0] cyc_now
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_q, st_d;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        st_d    = st_q;
        nxt     = st_q.cnt + 1'b1;
        win_end = run && (nxt >= win_len);
        cyc_now = nxt;
        if (!run || win_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lm_chan_meter.sv
module lm_chan_meter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             win_end,
    input  logic             burst,
    input  logic [CNT_W-1:0] cyc_now,
    input  logic [CNT_W-1:0] lo_thr,
    input  logic [CNT_W-1:0] hi_thr,
    output logic [CNT_W-1:0] lat_acc,
    output logic [CNT_W-1:0] lat_cyc,
    output logic             over_evt,
    output logic             below_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] lat_acc;
        logic [CNT_W-1:0] lat_cyc;
    } meter_t;

    meter_t st_q, st_d;
    logic [CNT_W-1:0] acc_now;
    logic [CNT_W-1:0] inc;

    always_comb begin
        st_d      = st_q;
        inc       = '0;
        inc[0]    = burst;
        acc_now   = st_q.acc + inc;
        over_evt  = win_end && (acc_now > hi_thr);
        below_evt = win_end && (acc_now < lo_thr);
        if (!run || win_end) begin
            st_d.acc = '0;
        end else begin
            st_d.acc = acc_now;
        end
        if (win_end) begin
            st_d.lat_acc = acc_now;
            st_d.lat_cyc = cyc_now;
        end
    end

    assign lat_acc = st_q.lat_acc;
    assign lat_cyc = st_q.lat_cyc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lm_regfile.sv
module lm_regfile
    import lm_pkg::*;
#(
    parameter int unsigned NCH   = 2,
    parameter int unsigned CNT_W = 32,
    localparam int unsigned SW   = 2 * NCH
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [AW-1:0]             bus_addr,
    input  logic                      bus_wen,
    input  logic [DW-1:0]             bus_wdata,
    output logic [DW-1:0]             bus_rdata,
    input  logic [NCH-1:0]            over_evt,
    input  logic [NCH-1:0]            below_evt,
    input  logic [NCH-1:0][CNT_W-1:0] lat_acc,
    input  logic [NCH-1:0][CNT_W-1:0] lat_cyc,
    output logic                      run,
    output logic [CNT_W-1:0]          win_len,
    output logic [CNT_W-1:0]          lo_thr,
    output logic [CNT_W-1:0]          hi_thr,
    output logic [CTRL_W-1:0]         ctrl_q,
    output logic [SW-1:0]             mask_q,
    output logic [SW-1:0]             status_q,
    output logic                      irq
);
    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [SW-1:0]     mask;
        logic [SW-1:0]     status;
        logic [CNT_W-1:0]  wlen;
        logic [CNT_W-1:0]  lo;
        logic [CNT_W-1:0]  hi;
    } regs_t;

    regs_t st_q, st_d;
    logic [SW-1:0] set_v;
    logic [SW-1:0] clr_v;
    logic [DW-1:0] rd;

    always_comb begin
        st_d  = st_q;
        set_v = '0;
        clr_v = '0;
        for (int i = 0; i < NCH; i++) begin
            set_v[2*i]   = below_evt[i];
            set_v[2*i+1] = over_evt[i];
        end
        if (bus_wen) begin
            unique case (bus_addr)
                OFF_CTRL: begin
                    for (int b = 0; b < CTRL_W; b++) begin
                        if (bus_wdata[16+b]) begin
                            st_d.ctrl[b] = bus_wdata[b];
                        end
                    end
                    st_d.ctrl = st_d.ctrl & CTRL_IMPL;
                end
                OFF_STAT: clr_v     = bus_wdata[SW-1:0];
                OFF_MASK: st_d.mask = bus_wdata[SW-1:0];
                OFF_WLEN: st_d.wlen = bus_wdata[CNT_W-1:0];
                OFF_LOW:  st_d.lo   = bus_wdata[CNT_W-1:0];
                OFF_HIGH: st_d.hi   = bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        st_d.status = (st_q.status & ~clr_v) | set_v;
    end

    always_comb begin
        rd = '0;
        unique case (bus_addr)
            OFF_CTRL: rd[CTRL_W-1:0] = st_q.ctrl;
            OFF_STAT: rd[SW-1:0]     = st_q.status;
            OFF_MASK: rd[SW-1:0]     = st_q.mask;
            OFF_WLEN: rd[CNT_W-1:0]  = st_q.wlen;
            OFF_LOW:  rd[CNT_W-1:0]  = st_q.lo;
            OFF_HIGH: rd[CNT_W-1:0]  = st_q.hi;
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (bus_addr == AW'(int'(OFF_CH_CYC) + i * CH_STRIDE)) begin
                        rd[CNT_W-1:0] = lat_cyc[i];
                    end
                    if (bus_addr == AW'(int'(OFF_CH_ACC) + i * CH_STRIDE)) begin
                        rd[CNT_W-1:0] = lat_acc[i];
                    end
                end
            end
        endcase
    end

    assign bus_rdata = rd;
    assign run       = st_q.ctrl[CB_TIMER] & st_q.ctrl[CB_MONITOR];
    assign win_len   = st_q.wlen;
    assign lo_thr    = st_q.lo;
    assign hi_thr    = st_q.hi;
    assign ctrl_q    = st_q.ctrl;
    assign mask_q    = st_q.mask;
    assign status_q  = st_q.status;
    assign irq       = |(st_q.status & ~st_q.mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/memload_monitor.sv
module memload_monitor
    import lm_pkg::*;
#(
    parameter int unsigned NCH   = 2,
    parameter int unsigned CNT_W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wen,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] chan_burst,
    output logic           irq
);
    localparam int unsigned SW = 2 * NCH;

    logic                      run;
    logic                      win_end;
    logic [CNT_W-1:0]          win_len;
    logic [CNT_W-1:0]          cyc_now;
    logic [CNT_W-1:0]          lo_thr;
    logic [CNT_W-1:0]          hi_thr;
    logic [NCH-1:0]            over_evt;
    logic [NCH-1:0]            below_evt;
    logic [NCH-1:0][CNT_W-1:0] lat_acc;
    logic [NCH-1:0][CNT_W-1:0] lat_cyc;
    logic [CTRL_W-1:0]         ctrl_q;
    logic [SW-1:0]             mask_q;
    logic [SW-1:0]             status_q;

    lm_window_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .win_len (win_len),
        .win_end (win_end),
        .cyc_now (cyc_now)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        lm_chan_meter #(.CNT_W(CNT_W)) u_meter (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run),
            .win_end   (win_end),
            .burst     (chan_burst[i]),
            .cyc_now   (cyc_now),
            .lo_thr    (lo_thr),
            .hi_thr    (hi_thr),
            .lat_acc   (lat_acc[i]),
            .lat_cyc   (lat_cyc[i]),
            .over_evt  (over_evt[i]),
            .below_evt (below_evt[i])
        );
    end

    lm_regfile #(.NCH(NCH), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .over_evt  (over_evt),
        .below_evt (below_evt),
        .lat_acc   (lat_acc),
        .lat_cyc   (lat_cyc),
        .run       (run),
        .win_len   (win_len),
        .lo_thr    (lo_thr),
        .hi_thr    (hi_thr),
        .ctrl_q    (ctrl_q),
        .mask_q    (mask_q),
        .status_q  (status_q),
        .irq       (irq)
    );
endmodule

// File: rtl/memload_monitor_chk.sv
module memload_monitor_chk
    import lm_pkg::*;
#(
    parameter int unsigned NCH   = 2,
    parameter int unsigned CNT_W = 32,
    localparam int unsigned SW   = 2 * NCH
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [AW-1:0]             bus_addr,
    input logic                      bus_wen,
    input logic [DW-1:0]             bus_wdata,
    input logic                      irq,
    input logic                      run,
    input logic                      win_end,
    input logic [CNT_W-1:0]          win_len,
    input logic [CTRL_W-1:0]         ctrl_q,
    input logic [SW-1:0]             mask_q,
    input logic [SW-1:0]             status_q,
    input logic [NCH-1:0][CNT_W-1:0] lat_acc,
    input logic [NCH-1:0][CNT_W-1:0] lat_cyc
);
    assert_ctrl_unmasked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == OFF_CTRL && bus_wdata[DW-1:16] == '0) |=> $stable(ctrl_q));

    assert_cycle_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && win_len > 1) |=> (lat_cyc[0] == $past(win_len)));

    assert_latch_only_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> ($stable(lat_acc) && $stable(lat_cyc)));

    assert_status_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q)) != '0) |-> $past(win_end));

    assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq);

    assert_idle_no_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(bus_wen && bus_addr == OFF_CTRL)) |=> !win_end);
endmodule

bind memload_monitor memload_monitor_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .run       (run),
    .win_end   (win_end),
    .win_len   (win_len),
    .ctrl_q    (ctrl_q),
    .mask_q    (mask_q),
    .status_q  (status_q),
    .lat_acc   (lat_acc),
    .lat_cyc   (lat_cyc)
);

// File: tb/memload_monitor_tb.sv
module memload_monitor_tb;
    localparam logic [7:0] A_CTRL = 8'h04, A_STAT = 8'h08, A_MASK = 8'h0C;
    localparam logic [7:0] A_WLEN = 8'h10, A_LOW = 8'h14, A_HIGH = 8'h18;
    localparam logic [7:0] A_CYC0 = 8'h28, A_ACC0 = 8'h2C, A_CYC1 = 8'h3C, A_ACC1 = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  chan_burst = '0;
    logic        irq;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    memload_monitor u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wen    (bus_wen),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .chan_burst (chan_burst),
        .irq        (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        chan_burst = '0;
        bus_addr   = a;
        bus_wdata  = d;
        bus_wen    = 1'b1;
        @(posedge clk);
        #1 bus_wen = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        @(negedge clk);
        peek(a, v);
        chk(tag, v, exp);
    endtask

    task automatic run_window(input int len, input int k0, input int k1);
        wr(A_CTRL, 32'h0009_0009);
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            chan_burst = {1'(j < k1), 1'(j < k0)};
        end
        wr(A_CTRL, 32'h0009_0000);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 reset state
        expect_reg("R11 ctrl", A_CTRL, 32'h0);
        expect_reg("R11 mask", A_MASK, 32'hF);
        expect_reg("R11 status", A_STAT, 32'h0);
        expect_reg("R11 wlen", A_WLEN, 32'h0);
        expect_reg("R11 acc1", A_ACC1, 32'h0);
        chk("R11 irq", {31'b0, irq}, 32'h0);

        // R1 hi-word masked control writes
        wr(A_CTRL, 32'h0000_001F); expect_reg("R1 no mask bits", A_CTRL, 32'h00);
        wr(A_CTRL, 32'h001F_0009); expect_reg("R1 full mask", A_CTRL, 32'h09);
        wr(A_CTRL, 32'h0004_0004); expect_reg("R1 set bit2 only", A_CTRL, 32'h0D);
        wr(A_CTRL, 32'h0008_0000); expect_reg("R1 clear bit3 only", A_CTRL, 32'h05);
        wr(A_CTRL, 32'h0002_0002); expect_reg("R1 bit1 unimplemented", A_CTRL, 32'h05);
        wr(A_CTRL, 32'h0005_0000); expect_reg("R1 clear rest", A_CTRL, 32'h00);

        // R2 register map
        wr(A_LOW, 32'd2);
        wr(A_HIGH, 32'd4);
        expect_reg("R2 low limit", A_LOW, 32'd2);
        expect_reg("R2 high limit", A_HIGH, 32'd4);
        expect_reg("R2 unmapped 0x00", 8'h00, 32'h0);
        expect_reg("R2 unmapped 0x20", 8'h20, 32'h0);

        // R3 R4 R5 R6 R7 R10 sweep of burst splits
        for (int li = 0; li < 2; li++) begin
            int len;
            len = (li == 0) ? 3 : 6;
            wr(A_WLEN, 32'(len));
            if (li == 1) wr(A_CTRL, 32'h0014_0014);
            for (int k0 = 0; k0 <= len; k0++) begin
                int k1;
                logic [31:0] es;
                k1 = len - k0;
                wr(A_STAT, 32'hF);
                run_window(len, k0, k1);
                es = {28'b0, 1'(k1 > 4), 1'(k1 < 2), 1'(k0 > 4), 1'(k0 < 2)};
                expect_reg("R4 acc ch0", A_ACC0, 32'(k0));
                expect_reg("R4 acc ch1", A_ACC1, 32'(k1));
                expect_reg("R3 cyc ch0", A_CYC0, 32'(len));
                expect_reg("R3 cyc ch1", A_CYC1, 32'(len));
                expect_reg("R5 R6 status", A_STAT, es);
            end
            if (li == 1) expect_reg("R10 mode bits kept", A_CTRL, 32'h14);
        end
        wr(A_CTRL, 32'h0014_0000);

        // R4 back-to-back windows, no loss at boundary
        wr(A_WLEN, 32'd5);
        wr(A_CTRL, 32'h0009_0009);
        for (int j = 0; j < 10; j++) begin
            @(negedge clk);
            if (j == 5) begin
                peek(A_ACC0, v); chk("R4 win1 ch0", v, 32'd5);
                peek(A_ACC1, v); chk("R4 win1 ch1", v, 32'd3);
            end
            chan_burst = {1'(j % 2 == 0), 1'b1};
        end
        wr(A_CTRL, 32'h0009_0000);
        expect_reg("R4 win2 ch0", A_ACC0, 32'd5);
        expect_reg("R4 win2 ch1", A_ACC1, 32'd2);

        // R3 one-cycle window
        wr(A_WLEN, 32'd1);
        wr(A_CTRL, 32'h0009_0009);
        @(negedge clk); chan_burst = 2'b01;
        @(negedge clk); chan_burst = 2'b00;
        peek(A_ACC0, v); chk("R3 len1 acc", v, 32'd1);
        peek(A_CYC0, v); chk("R3 len1 cyc", v, 32'd1);
        wr(A_CTRL, 32'h0009_0000);

        // R8 R7 interrupt masking and write-1-to-clear
        wr(A_WLEN, 32'd4);
        wr(A_STAT, 32'hF);
        run_window(4, 0, 4);
        expect_reg("R6 under ch0 only", A_STAT, 32'h1);
        wr(A_MASK, 32'hF); #2 chk("R8 all masked", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'hE); #2 chk("R8 bit0 open", {31'b0, irq}, 32'h1);
        wr(A_MASK, 32'h1); #2 chk("R8 other bits open", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h0); #2 chk("R8 none masked", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'hE); expect_reg("R7 zero bit keeps", A_STAT, 32'h1);
        wr(A_STAT, 32'h1); expect_reg("R7 one bit clears", A_STAT, 32'h0);
        #2 chk("R8 irq after clear", {31'b0, irq}, 32'h0);

        // R9 idle: only one of the two enables set
        wr(A_CTRL, 32'h0009_0001);
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            chan_burst = 2'b11;
        end
        wr(A_CTRL, 32'h0009_0008);
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            chan_burst = 2'b11;
        end
        expect_reg("R9 acc ch1 held", A_ACC1, 32'd4);
        expect_reg("R9 acc ch0 held", A_ACC0, 32'd0);
        expect_reg("R9 status held", A_STAT, 32'h0);
        // enabling now must start from zero counts
        wr(A_CTRL, 32'h0009_0000);
        run_window(4, 2, 3);
        expect_reg("R9 fresh start ch0", A_ACC0, 32'd2);
        expect_reg("R9 fresh start ch1", A_ACC1, 32'd3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule